// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM out of power-up once the asynchronous reset has been released. It steps through a fixed list of five encoded command words and presents them to the command port of an existing memory controller. Each word travels with a write strobe that lasts one clock cycle. Waits counted in system clock cycles separate the commands. The clock period and every wait are given in nanoseconds as parameters, and a function turns each one into a cycle count, rounding up.

The list has five commands. It opens with a precharge of all banks. Next comes an extended-mode load that switches the DLL on at normal drive strength. A mode-register load follows, setting burst length 2, sequential burst and CAS latency 2 with the DLL reset bit set. A second precharge comes after that. Refresh is enabled together with the second precharge and stays enabled. After a refresh wait long enough for at least two auto-refresh cycles, the mode register is loaded again with the same settings and the DLL reset bit cleared. After a final settling wait the block raises its done flag. From then on the controller may accept normal read and write traffic.

The block drives no memory pins. It has no refresh engine, no data path and no arbitration. It only sequences the controller's command port.

Top module: `ddrinit_seq`

## Requirements
- R1: Asserting `rst_n` low clears `cmd_wr`, `cmd_word`, `refresh_on` and `init_done` at once, without waiting for a clock edge. After release the whole sequence restarts from its beginning.
- R2: The first strobe (precharge) is high in the cycle that follows the P-th rising edge after reset release. P = ceil(POWERUP_NS*1000/CLK_PERIOD_PS), with a floor of 2. The same rounding and floor apply to every wait length.
- R3: The strobed words come in the fixed order 0x8000 (precharge all), 0x2000 (extended mode, DLL on), 0x0121 (mode, DLL reset set), 0x8000, 0x0021 (mode, DLL reset clear).
- R4: Strobes two, three and four each follow the previous strobe by exactly G clock cycles, where G is the cycle count of GAP_NS.
- R5: `cmd_wr` is never high for two consecutive cycles. `cmd_word` is 0x0000 in every cycle in which `cmd_wr` is low.
- R6: `refresh_on` rises in the same cycle as the strobe of the second precharge and stays high until reset.
- R7: The final mode-register strobe (0x0021) follows the second precharge strobe by exactly F cycles, where F is the cycle count of REFRESH_NS.
- R8: `init_done` rises exactly S cycles after the final strobe, where S is the cycle count of SETTLE_NS. It stays high until reset, and no strobe occurs while it is high.
- R9: Each run from reset release makes exactly five strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_word | output | 16 | Controller command word, zero when not strobed |
| cmd_wr | output | 1 | One-cycle write strobe for `cmd_word` |
| refresh_on | output | 1 | Enables the controller's auto-refresh |
| init_done | output | 1 | Memory ready for normal requests |

## Verification
The only free input is reset, so the hardest case to reach is a reset that arrives mid-sequence. This includes a reset in the exact cycle a command is strobed, and a reset after refresh has already been enabled. The stimulus releases reset, lets the sequence run for a random number of cycles, and then asserts reset at a random point inside a clock period. It does this from a fixed seed. A directed trial also aborts on the second precharge strobe. After each abort the outputs must clear at once, and the following run must replay the full timed list from its start.

// File: rtl/ddrinit_pkg.sv
package ddrinit_pkg;

  localparam logic [15:0] CMD_PRECHARGE_ALL  = 16'h8000;
  localparam logic [15:0] CMD_EXT_MODE_DLLON = 16'h2000;
  localparam logic [15:0] CMD_MODE_DLLRESET  = 16'h0121;
  localparam logic [15:0] CMD_MODE_RUN       = 16'h0021;

  localparam int unsigned NUM_STEPS = 5;
  localparam int unsigned IDX_W     = 3;
  localparam int unsigned MIN_WAIT  = 2;

  typedef enum logic [1:0] {
    WSEL_GAP     = 2'd0,
    WSEL_REFRESH = 2'd1,
    WSEL_SETTLE  = 2'd2
  } wait_sel_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_READY = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic [15:0] word;
    logic        arm_refresh;
    wait_sel_e   wait_sel;
  } step_t;

  // Converts a delay in ns into whole clock cycles, rounded up, with a floor
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * 64'd1000;
    cyc  = (prod + longint'(period_ps) - 64'd1) / longint'(period_ps);
    if (cyc < longint'(MIN_WAIT)) cyc = longint'(MIN_WAIT);
    return int'(cyc);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Step table: word, refresh arming, and which wait follows the strobe
  function automatic step_t step_lookup(input logic [IDX_W-1:0] idx);
    step_t s;
    s = '{word: 16'h0000, arm_refresh: 1'b0, wait_sel: WSEL_SETTLE};
    case (idx)
      3'd0: s = '{word: CMD_PRECHARGE_ALL,  arm_refresh: 1'b0, wait_sel: WSEL_GAP};
      3'd1: s = '{word: CMD_EXT_MODE_DLLON, arm_refresh: 1'b0, wait_sel: WSEL_GAP};
      3'd2: s = '{word: CMD_MODE_DLLRESET,  arm_refresh: 1'b0, wait_sel: WSEL_GAP};
      3'd3: s = '{word: CMD_PRECHARGE_ALL,  arm_refresh: 1'b1, wait_sel: WSEL_REFRESH};
      3'd4: s = '{word: CMD_MODE_RUN,       arm_refresh: 1'b0, wait_sel: WSEL_SETTLE};
      default: s = '{word: 16'h0000, arm_refresh: 1'b0, wait_sel: WSEL_SETTLE};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddrinit_timer.sv
module ddrinit_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RESET_VAL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_CNT;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddrinit_fsm.sv
module ddrinit_fsm
  import ddrinit_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned GAP_CYC = 2,
  parameter int unsigned REF_CYC = 2,
  parameter int unsigned SET_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired,
  output logic             run,
  output logic             issue_evt,
  output logic             finish_evt,
  output logic [CNT_W-1:0] reload_val,
  output step_t            cur_step,
  output logic [IDX_W-1:0] step_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] REF_LD   = CNT_W'(REF_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LD   = CNT_W'(SET_CYC - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign run        = (state_q == ST_RUN);
  assign cur_step   = step_lookup(idx_q);
  assign issue_evt  = run && expired && (idx_q != LAST_IDX);
  assign finish_evt = run && expired && (idx_q == LAST_IDX);
  assign step_idx   = idx_q;

  always_comb begin
    case (cur_step.wait_sel)
      WSEL_GAP:     reload_val = GAP_LD;
      WSEL_REFRESH: reload_val = REF_LD;
      default:      reload_val = SET_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
    end else if (issue_evt) begin
      idx_q <= idx_q + 1'b1;
    end else if (finish_evt) begin
      state_q <= ST_READY;
    end
  end

endmodule

// File: rtl/ddrinit_outreg.sv
module ddrinit_outreg
  import ddrinit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_evt,
  input  logic        finish_evt,
  input  step_t       cur_step,
  output logic [15:0] cmd_word,
  output logic        cmd_wr,
  output logic        refresh_on,
  output logic        init_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word   <= 16'h0000;
      cmd_wr     <= 1'b0;
      refresh_on <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      cmd_wr     <= issue_evt;
      cmd_word   <= issue_evt ? cur_step.word : 16'h0000;
      refresh_on <= refresh_on | (issue_evt & cur_step.arm_refresh);
      init_done  <= init_done | finish_evt;
    end
  end

endmodule

// File: rtl/ddrinit_seq.sv
module ddrinit_seq
  import ddrinit_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned POWERUP_NS    = 201000,
  parameter int unsigned GAP_NS        = 1000,
  parameter int unsigned REFRESH_NS    = 30000,
  parameter int unsigned SETTLE_NS     = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] cmd_word,
  output logic        cmd_wr,
  output logic        refresh_on,
  output logic        init_done
);

  localparam int unsigned PWR_CYC = ns_to_cycles(POWERUP_NS, CLK_PERIOD_PS);
  localparam int unsigned GAP_CYC = ns_to_cycles(GAP_NS, CLK_PERIOD_PS);
  localparam int unsigned REF_CYC = ns_to_cycles(REFRESH_NS, CLK_PERIOD_PS);
  localparam int unsigned SET_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = max2(max2(PWR_CYC, GAP_CYC), max2(REF_CYC, SET_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             run;
  logic             expired;
  logic             issue_evt;
  logic             finish_evt;
  logic [CNT_W-1:0] reload_val;
  step_t            cur_step;
  logic [IDX_W-1:0] step_idx;

  ddrinit_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(PWR_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .load    (issue_evt),
    .load_val(reload_val),
    .expired (expired)
  );

  ddrinit_fsm #(
    .CNT_W  (CNT_W),
    .GAP_CYC(GAP_CYC),
    .REF_CYC(REF_CYC),
    .SET_CYC(SET_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired   (expired),
    .run       (run),
    .issue_evt (issue_evt),
    .finish_evt(finish_evt),
    .reload_val(reload_val),
    .cur_step  (cur_step),
    .step_idx  (step_idx)
  );

  ddrinit_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_evt (issue_evt),
    .finish_evt(finish_evt),
    .cur_step  (cur_step),
    .cmd_word  (cmd_word),
    .cmd_wr    (cmd_wr),
    .refresh_on(refresh_on),
    .init_done (init_done)
  );

endmodule

// File: rtl/ddrinit_seq_chk.sv
module ddrinit_seq_chk
  import ddrinit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      cmd_word,
  input logic             cmd_wr,
  input logic             refresh_on,
  input logic             init_done,
  input logic             issue_evt,
  input logic             finish_evt,
  input logic [IDX_W-1:0] step_idx
);

  assert_clear_on_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cmd_wr && !refresh_on && !init_done && cmd_word == 16'h0000));

  assert_legal_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_word == CMD_PRECHARGE_ALL || cmd_word == CMD_EXT_MODE_DLLON ||
                cmd_word == CMD_MODE_DLLRESET || cmd_word == CMD_MODE_RUN));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr);

  assert_idle_word_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |-> (cmd_word == 16'h0000));

  assert_issue_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> cmd_wr);

  assert_refresh_with_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_on) |-> (cmd_wr && cmd_word == CMD_PRECHARGE_ALL));

  assert_refresh_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_on |=> refresh_on);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!cmd_wr && refresh_on));

  assert_finish_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> init_done);

  assert_step_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= IDX_W'(NUM_STEPS));

endmodule

bind ddrinit_seq ddrinit_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_word  (cmd_word),
  .cmd_wr    (cmd_wr),
  .refresh_on(refresh_on),
  .init_done (init_done),
  .issue_evt (issue_evt),
  .finish_evt(finish_evt),
  .step_idx  (step_idx)
);

// File: tb/ddrinit_seq_tb.sv
`timescale 1ns/1ps
module ddrinit_seq_tb;

  localparam int unsigned PERIOD_PS = 5000;
  localparam int unsigned PWR_NS    = 203;
  localparam int unsigned GAP_NS    = 47;
  localparam int unsigned REF_NS    = 150;
  localparam int unsigned SET_NS    = 58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word;
  logic        cmd_wr;
  logic        refresh_on;
  logic        init_done;

  int unsigned n_cyc;
  int          checks = 0;
  int          fails = 0;
  int          strobes = 0;
  bit          done_flag = 0;

  always #2.5 clk = ~clk;

  ddrinit_seq #(
    .CLK_PERIOD_PS(PERIOD_PS),
    .POWERUP_NS   (PWR_NS),
    .GAP_NS       (GAP_NS),
    .REFRESH_NS   (REF_NS),
    .SETTLE_NS    (SET_NS)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_word  (cmd_word),
    .cmd_wr    (cmd_wr),
    .refresh_on(refresh_on),
    .init_done (init_done)
  );

  // Rising edges seen since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) n_cyc <= 0;
    else        n_cyc <= n_cyc + 1;

  function automatic int unsigned cyc_of(input int unsigned ns);
    int unsigned whole;
    whole = (ns * 1000) / PERIOD_PS;
    if ((ns * 1000) % PERIOD_PS != 0) whole++;
    return (whole < 2) ? 2 : whole;
  endfunction

  function automatic int unsigned edge_of(input int k);
    int unsigned e;
    e = cyc_of(PWR_NS);
    if (k >= 1) e += cyc_of(GAP_NS) * ((k >= 3) ? 3 : k);
    if (k >= 4) e += cyc_of(REF_NS);
    return e;
  endfunction

  function automatic logic [15:0] word_of(input int k);
    case (k)
      0: return 16'h8000;
      1: return 16'h2000;
      2: return 16'h0121;
      3: return 16'h8000;
      default: return 16'h0021;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, n_cyc);
    end
  endtask

  // Sampled at negedge: compare every output against the timed list
  task automatic check_cycle();
    int          k_hit;
    logic [15:0] w_exp;
    bit          r_exp;
    bit          d_exp;
    string       tag;
    k_hit = -1;
    if (n_cyc != 0)
      for (int k = 0; k < 5; k++) if (n_cyc == edge_of(k)) k_hit = k;
    w_exp = (k_hit >= 0) ? word_of(k_hit) : 16'h0000;
    r_exp = (n_cyc != 0) && (n_cyc >= edge_of(3));
    d_exp = (n_cyc != 0) && (n_cyc >= edge_of(4) + cyc_of(SET_NS));
    tag = (k_hit == 0) ? "R2" : (k_hit == 4) ? "R7" : (k_hit > 0) ? "R4" : "R5";
    check(cmd_wr === (k_hit >= 0), tag, "cmd_wr", {15'd0, cmd_wr}, {15'd0, k_hit >= 0});
    check(cmd_word === w_exp, (k_hit >= 0) ? "R3" : "R5", "cmd_word", cmd_word, w_exp);
    check(refresh_on === r_exp, "R6", "refresh_on", {15'd0, refresh_on}, {15'd0, r_exp});
    check(init_done === d_exp, "R8", "init_done", {15'd0, init_done}, {15'd0, d_exp});
    if (cmd_wr === 1'b1) strobes++;
  endtask

  task automatic run_cycles(input int num);
    for (int i = 0; i < num; i++) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    strobes = 0;
  endtask

  // Reset at a point inside the period, then outputs must be clear at once (R1)
  task automatic abort_at(input real offs);
    #(offs);
    rst_n = 1'b0;
    #0.1;
    check({cmd_wr, refresh_on, init_done} === 3'b000 && cmd_word === 16'h0000,
          "R1", "async clear", {cmd_word[12:0], cmd_wr, refresh_on, init_done}, 16'h0000);
    run_cycles(2);
  endtask

  initial begin
    int unsigned total;
    void'($urandom(32'h5EED_0042));
    total = edge_of(4) + cyc_of(SET_NS);
    run_cycles(3);

    // Directed: complete run and idle tail
    release_reset();
    run_cycles(total + 40);
    check(strobes == 5, "R9", "strobe count", 16'(strobes), 16'd5);
    abort_at(1.0);

    // Directed: abort on the second precharge strobe, then full replay
    release_reset();
    run_cycles(edge_of(3));
    abort_at(0.4);
    release_reset();
    run_cycles(total + 10);
    check(strobes == 5, "R9", "strobe count after abort", 16'(strobes), 16'd5);
    abort_at(2.0);

    // Random aborts at random points in the sequence
    for (int t = 0; t < 10; t++) begin
      int unsigned len;
      int unsigned tenth;
      len   = 1 + ($urandom % (total + 10));
      tenth = 2 + 2 * ($urandom % 20);
      release_reset();
      run_cycles(len);
      abort_at(real'(tenth) / 10.0);
    end

    // Final full run after the random trials
    release_reset();
    run_cycles(total + 5);
    check(strobes == 5, "R9", "strobe count final", 16'(strobes), 16'd5);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule